// File: doc/BRIEF.md
# Short Loop Replay Buffer

This block sits behind the decoder of a pipelined core and watches the decoded instruction stream for a tight loop. When a taken backward branch jumps to a target close enough behind it, the block records each decoded instruction that follows. It keeps the path actually executed, including the direction of any forward branch on it. When that same backward branch is seen taken a second time, the recording is complete and the block switches to replay.

During replay the recorded instructions are issued again in order, one per cycle, and wrap around at the loop end. The upstream fetch unit and most of the decoder can be powered down. Replay ends when the core reports a redirect of any kind, such as a misprediction, an exception or an external redirect. It also ends when a replayed branch resolves in the other direction from the one it had when it was recorded.

On either exit the recorded loop is discarded. Fetch is re-enabled one cycle before decode, which gives one cycle of handoff. A recording is abandoned, and normal operation goes on, if the loop body would hold a third forward branch, a second backward branch or more entries than the buffer holds.

Top module: `loop_replay_buf`

## Requirements
- R1: After reset, `rep_valid`, `fetch_off` and `decode_off` are all low.
- R2: The branch kind `in_kind` is encoded as 2'b00 for not a branch, 2'b01 for a forward branch and 2'b10 for a backward branch. A valid taken backward branch with `in_tgt <= in_pc` and `in_pc - in_tgt < DEPTH` starts a recording, which begins with the next valid instruction. When that same `in_pc` is next seen as a taken backward branch, it is recorded as the last entry, and `rep_valid` is high at the following clock edge with `rep_idx` equal to 0.
- R3: During replay, one entry is issued per cycle in recording order (`rep_idx` 0, 1, … up to the length minus 1, then 0 again). `rep_instr`, `rep_kind` and `rep_taken` equal the values that were recorded for that entry.
- R4: In every cycle in which `rep_valid` is high, both `fetch_off` and `decode_off` are high.
- R5: A recording keeps up to two forward branches. A third forward branch abandons the recording, and no replay follows.
- R6: During recording, a backward branch that is not the closing branch abandons the recording. This covers a branch at a different address and the closing branch seen not taken.
- R7: A taken backward branch whose distance to its target is DEPTH or more starts no recording. A loop of exactly DEPTH entries is recorded and replayed, wrapping from index DEPTH-1 to 0.
- R8: A `flush` during replay drops `rep_valid` and `fetch_off` at the next edge while `decode_off` stays high for exactly one more cycle. The recorded loop is then invalid and replay does not resume.
- R9: A `flush` during recording abandons the recording.
- R10: During replay, a `res_valid` with `res_taken` different from the recorded direction of entry `res_idx` exits with the same handoff as R8. A resolution that agrees with the recorded direction has no effect.
- R11: `in_valid` and the instruction inputs are ignored during replay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_instr | input | IW | Decoded instruction word |
| in_pc | input | AW | Instruction address, in instruction units |
| in_kind | input | 2 | Branch kind: 00 none, 01 forward, 10 backward |
| in_taken | input | 1 | Predicted direction of the branch |
| in_tgt | input | AW | Branch target address |
| flush | input | 1 | Misprediction, exception or external redirect |
| res_valid | input | 1 | A replayed branch has resolved |
| res_idx | input | $clog2(DEPTH) | Buffer index of the resolved branch |
| res_taken | input | 1 | Resolved direction |
| rep_valid | output | 1 | Replayed instruction present |
| rep_instr | output | IW | Replayed instruction word |
| rep_kind | output | 2 | Recorded branch kind of the replayed entry |
| rep_taken | output | 1 | Recorded direction of the replayed entry |
| rep_idx | output | $clog2(DEPTH) | Buffer index of the replayed entry |
| fetch_off | output | 1 | Fetch stage disabled |
| decode_off | output | 1 | Decode stage disabled |

## Verification
The hardest condition to reach from the ports is a recording that holds a taken forward branch. The recorded path then skips addresses, and replay must follow the skipped path rather than the address range. The stimulus builds a loop whose first pass takes one forward branch and falls through another. It then walks the replay across the wrap and checks that the skipped address never appears. Next it sends one resolution that agrees with the recorded direction and one that disagrees, and observes whether replay survives each.

// File: rtl/loop_replay_buf.sv
module loop_replay_buf #(
  parameter int DEPTH = 32,
  parameter int IW = 32,
  parameter int AW = 32,
  localparam int IXW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [IW-1:0]  in_instr,
  input  logic [AW-1:0]  in_pc,
  input  logic [1:0]     in_kind,
  input  logic           in_taken,
  input  logic [AW-1:0]  in_tgt,
  input  logic           flush,
  input  logic           res_valid,
  input  logic [IXW-1:0] res_idx,
  input  logic           res_taken,
  output logic           rep_valid,
  output logic [IW-1:0]  rep_instr,
  output logic [1:0]     rep_kind,
  output logic           rep_taken,
  output logic [IXW-1:0] rep_idx,
  output logic           fetch_off,
  output logic           decode_off
);

  typedef enum logic [1:0] {S_IDLE, S_CAP, S_REP, S_HAND} st_t;

  st_t            st;
  logic [CW-1:0]  cnt, len;
  logic [1:0]     nfwd;
  logic [IXW-1:0] rd;
  logic [AW-1:0]  loop_pc;

  logic [IW-1:0]  mem_i [DEPTH];
  logic [1:0]     mem_k [DEPTH];
  logic           mem_t [DEPTH];

  wire is_fwd   = in_kind == 2'b01;
  wire is_bwd   = in_kind == 2'b10;
  wire short_bk = (in_tgt <= in_pc) && ((in_pc - in_tgt) < AW'(DEPTH));
  wire start    = in_valid && !flush && is_bwd && in_taken && short_bk;
  wire closing  = is_bwd && in_taken && (in_pc == loop_pc);
  wire cap_full = cnt == CW'(DEPTH);
  wire cap_abort = cap_full || (is_fwd && nfwd == 2'd2) || (is_bwd && !closing);
  wire wr_en    = (st == S_CAP) && in_valid && !flush && !cap_abort;
  wire rd_last  = CW'(rd) == len - CW'(1);
  wire mis      = res_valid && (CW'(res_idx) < len) && (res_taken != mem_t[res_idx]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      len <= '0;
      nfwd <= '0;
      rd <= '0;
      loop_pc <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (start) begin
            st <= S_CAP;
            loop_pc <= in_pc;
            cnt <= '0;
            nfwd <= '0;
          end
        S_CAP:
          if (flush) st <= S_IDLE;
          else if (in_valid) begin
            if (cap_abort) st <= S_IDLE;
            else begin
              cnt <= cnt + CW'(1);
              if (is_fwd) nfwd <= nfwd + 2'd1;
              if (closing) begin
                st <= S_REP;
                len <= cnt + CW'(1);
                rd <= '0;
              end
            end
          end
        S_REP:
          if (flush || mis) begin
            st <= S_HAND;
            len <= '0;
          end else rd <= rd_last ? '0 : rd + IXW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (wr_en) begin
      mem_i[cnt[IXW-1:0]] <= in_instr;
      mem_k[cnt[IXW-1:0]] <= in_kind;
      mem_t[cnt[IXW-1:0]] <= in_taken;
    end

  assign rep_valid  = st == S_REP;
  assign fetch_off  = st == S_REP;
  assign decode_off = (st == S_REP) || (st == S_HAND);
  assign rep_idx    = rd;
  assign rep_instr  = mem_i[rd];
  assign rep_kind   = mem_k[rd];
  assign rep_taken  = mem_t[rd];

  // R2
  commit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_off) |-> $past(in_valid && in_kind == 2'b10 && in_taken));

  // R3
  rep_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && $past(rep_valid) && rep_idx != '0) |-> rep_idx == $past(rep_idx) + IXW'(1));

  // R8
  flush_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_off && flush) |=> (!fetch_off && !rep_valid && decode_off));

  // R8
  handoff_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fetch_off) |=> !decode_off);

  // R10
  mis_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_off && mis) |=> !fetch_off);

endmodule

// File: tb/tb_loop_replay_buf.sv
module tb_loop_replay_buf;
  localparam int DEPTH = 32;
  localparam int IXW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_taken = 0, flush = 0, res_valid = 0, res_taken = 0;
  logic [31:0] in_instr = 0, in_pc = 0, in_tgt = 0;
  logic [1:0] in_kind = 0;
  logic [IXW-1:0] res_idx = 0;
  logic rep_valid, rep_taken, fetch_off, decode_off;
  logic [31:0] rep_instr;
  logic [1:0] rep_kind;
  logic [IXW-1:0] rep_idx;
  int nvec = 0, nerr = 0;

  always #2 clk = ~clk;

  loop_replay_buf #(.DEPTH(DEPTH)) dut (.*);

  initial begin
    #400000;
    $display("FAIL watchdog expired");
    nerr++;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; in_valid = 0; flush = 0; res_valid = 0;
    tick(); tick();
    @(negedge clk); rst_n = 1;
  endtask

  task automatic send(input int pc, input logic [1:0] k, input logic t, input int tgt);
    @(negedge clk);
    in_valid = 1; in_pc = pc; in_kind = k; in_taken = t; in_tgt = tgt;
    in_instr = 32'hA000_0000 | pc;
    tick();
    in_valid = 0;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1; tick(); flush = 0;
  endtask

  task automatic pulse_res(input int idx, input logic t);
    @(negedge clk); res_valid = 1; res_idx = idx[IXW-1:0]; res_taken = t; tick(); res_valid = 0;
  endtask

  task automatic build_loop(input int lo, input int hi);
    send(hi, 2'b10, 1, lo);
    for (int p = lo; p < hi; p++) send(p, 2'b00, 0, 0);
    send(hi, 2'b10, 1, lo);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 rep_valid", rep_valid, 0);
    chk("R1 fetch_off", fetch_off, 0);
    chk("R1 decode_off", decode_off, 0);
  endtask

  task automatic t_basic();
    do_reset();
    build_loop(10, 15);
    chk("R2 replay starts", rep_valid, 1);
    chk("R2 first idx", rep_idx, 0);
    chk("R2 first instr", rep_instr, 32'hA000_0000 | 10);
    chk("R4 fetch_off", fetch_off, 1);
    chk("R4 decode_off", decode_off, 1);
    for (int k = 1; k <= 12; k++) begin
      tick();
      chk("R3 idx", rep_idx, k % 6);
      chk("R3 instr", rep_instr, 32'hA000_0000 | (10 + k % 6));
      chk("R4 fetch_off held", fetch_off, 1);
    end
    pulse_flush();
    chk("R8 rep_valid drop", rep_valid, 0);
    chk("R8 fetch back", fetch_off, 0);
    chk("R8 decode handoff", decode_off, 1);
    tick();
    chk("R8 decode back", decode_off, 0);
    tick(); tick();
    chk("R8 invalidated", rep_valid, 0);
  endtask

  task automatic t_fwd();
    int seq[7] = '{20, 21, 22, 23, 25, 26, 27};
    do_reset();
    send(27, 2'b10, 1, 20);
    send(20, 2'b00, 0, 0);
    send(21, 2'b01, 0, 24);
    send(22, 2'b00, 0, 0);
    send(23, 2'b01, 1, 25);
    send(25, 2'b00, 0, 0);
    send(26, 2'b00, 0, 0);
    send(27, 2'b10, 1, 20);
    chk("R5 two forward kept", rep_valid, 1);
    for (int k = 0; k < 14; k++) begin
      chk("R3 fwd path idx", rep_idx, k % 7);
      chk("R3 fwd path instr", rep_instr, 32'hA000_0000 | seq[k % 7]);
      if (k % 7 == 1) chk("R3 kind fwd", rep_kind, 2'b01);
      if (k % 7 == 3) chk("R3 taken rec", rep_taken, 1);
      if (k % 7 == 1) chk("R3 nt rec", rep_taken, 0);
      tick();
    end
    pulse_res(3, 1);
    chk("R10 agree ignored", rep_valid, 1);
    chk("R10 agree fetch", fetch_off, 1);
    pulse_res(1, 1);
    chk("R10 mismatch exit", fetch_off, 0);
    chk("R10 mismatch rep", rep_valid, 0);
    chk("R10 handoff decode", decode_off, 1);
    tick();
    chk("R10 decode back", decode_off, 0);
  endtask

  task automatic t_third_fwd();
    do_reset();
    send(30, 2'b10, 1, 20);
    send(20, 2'b00, 0, 0);
    send(21, 2'b01, 0, 29);
    send(22, 2'b01, 0, 29);
    send(23, 2'b01, 0, 29);
    for (int p = 24; p < 30; p++) send(p, 2'b00, 0, 0);
    send(30, 2'b10, 1, 20);
    chk("R5 third fwd abandons", fetch_off, 0);
    chk("R5 no replay", rep_valid, 0);
  endtask

  task automatic t_bwd();
    do_reset();
    send(30, 2'b10, 1, 20);
    send(20, 2'b00, 0, 0);
    send(21, 2'b10, 1, 20);
    for (int p = 22; p < 30; p++) send(p, 2'b00, 0, 0);
    send(30, 2'b10, 1, 20);
    chk("R6 inner bwd abandons", rep_valid, 0);
    do_reset();
    send(30, 2'b10, 1, 20);
    for (int p = 20; p < 30; p++) send(p, 2'b00, 0, 0);
    send(30, 2'b10, 0, 20);
    for (int p = 20; p < 30; p++) send(p, 2'b00, 0, 0);
    send(30, 2'b10, 1, 20);
    chk("R6 not-taken close abandons", fetch_off, 0);
  endtask

  task automatic t_dist();
    do_reset();
    build_loop(100, 132);
    chk("R7 too far no replay", rep_valid, 0);
    do_reset();
    build_loop(100, 131);
    chk("R7 full loop replays", rep_valid, 1);
    for (int k = 0; k < 31; k++) tick();
    chk("R7 last idx", rep_idx, 31);
    chk("R7 last instr", rep_instr, 32'hA000_0000 | 131);
    tick();
    chk("R7 wrap idx", rep_idx, 0);
    chk("R7 wrap instr", rep_instr, 32'hA000_0000 | 100);
  endtask

  task automatic t_cap_flush();
    do_reset();
    send(15, 2'b10, 1, 10);
    send(10, 2'b00, 0, 0);
    send(11, 2'b00, 0, 0);
    pulse_flush();
    for (int p = 12; p < 15; p++) send(p, 2'b00, 0, 0);
    send(15, 2'b10, 1, 10);
    chk("R9 flush abandons capture", fetch_off, 0);
  endtask

  task automatic t_ignore();
    do_reset();
    build_loop(10, 13);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      in_valid = 1; in_pc = 50; in_kind = 2'b10; in_taken = 1; in_tgt = 40; in_instr = 32'hDEAD_BEEF;
      tick();
      in_valid = 0;
      chk("R11 idx", rep_idx, k % 4);
      chk("R11 instr", rep_instr, 32'hA000_0000 | (10 + k % 4));
      chk("R11 still replaying", fetch_off, 1);
    end
  endtask

  initial begin
    t_reset();
    t_basic();
    t_fwd();
    t_third_fwd();
    t_bwd();
    t_dist();
    t_cap_flush();
    t_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule